// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

The block holds one redirection entry per interrupt input pin and turns pin activity into interrupt messages. Each message carries an 8-bit vector and an 8-bit destination. Software reaches the entries through a two-register indirect window. An 8-bit index register selects a 32-bit entry word, and a 32-bit data register reads or writes that word. Each entry has a vector field, a trigger-mode bit, a mask bit, a read-only remote-IRR status bit and a destination field.

Edge-mode entries send one message for each rising edge seen while unmasked. Level-mode entries send a message while the pin is high, unmasked and remote IRR is clear. Delivery sets remote IRR, which blocks the entry until an end-of-interrupt (EOI) broadcast arrives carrying the entry's current vector. If software rewrites the vector before that EOI arrives, the late EOI no longer matches, and the entry stays blocked. Software is therefore expected to confirm that remote IRR is clear before it moves an entry.

Messages leave on a valid/ready stream. Pending pins are served lowest pin first, one message at a time. A message that is presented stays unchanged until the receiver takes it, so back-pressure only delays delivery and never drops or alters a message. The EOI input is always accepted and has no ready signal.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every entry reads low word 0x0001_0000 (masked, edge mode, vector 0, remote IRR clear) and high word 0, and `msg_valid` is low.
- R2: A data write updates the entry word selected by the index: index 0x10+2p is the low word of pin p and 0x11+2p is its high word. A data read returns the selected word. An index outside that range reads 0, and writes to it have no effect.
- R3: Bit 14 of the low word is remote IRR. It reads back the status, and data writes never change it.
- R4: A message carries the entry's low-word bits 7:0 as the vector and high-word bits 31:24 as the destination.
- R5: In edge mode (low-word bit 15 = 0), each rising edge on an unmasked pin produces exactly one message, and remote IRR stays clear.
- R6: Low-word bit 16 = 1 masks the entry. A rising edge while masked is dropped and is not delivered after a later unmask.
- R7: In level mode (bit 15 = 1), delivery sets remote IRR, and no further message leaves that entry while it is set, even with the pin held high.
- R8: An EOI clears remote IRR on every level-mode entry whose current vector equals the EOI vector. An EOI that matches no entry changes nothing.
- R9: After the vector of a stalled level entry is rewritten, an EOI carrying the old vector leaves remote IRR set, and no message is sent.
- R10: When several entries request at once, messages go out one at a time, lowest pin first.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vector` and `msg_dest` hold.
- R12: A pin change made between clock edges shows on `msg_valid` after the second following rising edge. A message accepted at an edge is replaced at that same edge by the next pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pin | input | NPINS | Interrupt input pins |
| idx_we | input | 1 | Write strobe for the index register |
| idx_wdata | input | 8 | New index value |
| data_we | input | 1 | Write strobe for the selected entry word |
| data_wdata | input | 32 | Data written to the selected word |
| data_rdata | output | 32 | Selected entry word (0 when out of range) |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_valid | output | 1 | Interrupt message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |

## Verification
A pin change or an EOI takes two rising edges to reach `msg_valid`. The first edge registers the pin or updates remote IRR, and the second loads the output register. The bench drives on falling edges and samples on the falling edge after the second rising edge. Register writes are visible on `data_rdata` right after the writing edge, so readbacks are sampled one half-cycle later. A handover after acceptance happens at the accepting edge itself, so the next message is checked on the falling edge that follows that edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam logic [7:0] RTE_BASE = 8'h10;
  localparam int LO_RIRR  = 14;
  localparam int LO_LEVEL = 15;
  localparam int LO_MASK  = 16;
  localparam int HI_DEST_LSB = 24;
  localparam logic [WORD_W-1:0] LO_RESET = 32'h0001_0000;

  typedef struct packed {
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
  } irq_msg_t;
endpackage

// File: rtl/irq_rte_slot.sv
module irq_rte_slot
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vec,
  input  logic              grant,
  output logic              req,
  output logic [WORD_W-1:0] lo_word,
  output logic [WORD_W-1:0] hi_word,
  output irq_msg_t          msg,
  output logic              level,
  output logic              rirr
);
  logic [WORD_W-1:0] lo_q, hi_q;
  logic pin_q, pend_q, rirr_q;
  logic masked, rise, eoi_hit;

  assign masked  = lo_q[LO_MASK];
  assign level   = lo_q[LO_LEVEL];
  assign rise    = pin && !pin_q;
  assign eoi_hit = eoi_valid && level && (lo_q[VEC_W-1:0] == eoi_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= LO_RESET;
      hi_q   <= '0;
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      pin_q <= pin;
      if (wr_lo) lo_q <= {wdata[WORD_W-1:LO_RIRR+1], 1'b0, wdata[LO_RIRR-1:0]};
      if (wr_hi) hi_q <= wdata;
      if (level)                pend_q <= 1'b0;
      else if (rise && !masked) pend_q <= 1'b1;
      else if (grant)           pend_q <= 1'b0;
      if (grant && level)       rirr_q <= 1'b1;
      else if (eoi_hit)         rirr_q <= 1'b0;
    end
  end

  assign req      = level ? (pin_q && !masked && !rirr_q) : (pend_q && !masked);
  assign lo_word  = {lo_q[WORD_W-1:LO_RIRR+1], rirr_q, lo_q[LO_RIRR-1:0]};
  assign hi_word  = hi_q;
  assign msg.vec  = lo_q[VEC_W-1:0];
  assign msg.dest = hi_q[HI_DEST_LSB +: DEST_W];
  assign rirr     = rirr_q;
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
  import irq_route_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] req,
  input  irq_msg_t         msgs [NPINS],
  input  logic             out_ready,
  output logic [NPINS-1:0] grant,
  output logic             out_valid,
  output irq_msg_t         out_msg
);
  logic     load, found;
  irq_msg_t sel_msg;

  assign load = !out_valid || out_ready;

  always_comb begin
    grant   = '0;
    found   = 1'b0;
    sel_msg = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (req[i] && !found) begin
        found   = 1'b1;
        sel_msg = msgs[i];
        grant[i] = load;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else if (load) begin
      out_valid <= found;
      if (found) out_msg <= sel_msg;
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  irq_pin,
  input  logic              idx_we,
  input  logic [7:0]        idx_wdata,
  input  logic              data_we,
  input  logic [WORD_W-1:0] data_wdata,
  output logic [WORD_W-1:0] data_rdata,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [DEST_W-1:0] msg_dest
);
  localparam int IDX_END = int'(RTE_BASE) + 2 * NPINS;

  logic [7:0]        index_q;
  logic [7:0]        offset;
  logic              in_range;
  logic [NPINS-1:0]  slot_req, slot_grant, slot_level, slot_rirr;
  logic [WORD_W-1:0] lo_words [NPINS];
  logic [WORD_W-1:0] hi_words [NPINS];
  irq_msg_t          slot_msgs [NPINS];
  irq_msg_t          out_msg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      index_q <= '0;
    else if (idx_we) index_q <= idx_wdata;
  end

  assign offset   = index_q - RTE_BASE;
  assign in_range = (int'(index_q) >= int'(RTE_BASE)) && (int'(index_q) < IDX_END);

  for (genvar g = 0; g < NPINS; g++) begin : g_slot
    logic hit;
    assign hit = in_range && (offset[7:1] == 7'(g));
    irq_rte_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (irq_pin[g]),
      .wr_lo    (data_we && hit && !index_q[0]),
      .wr_hi    (data_we && hit && index_q[0]),
      .wdata    (data_wdata),
      .eoi_valid(eoi_valid),
      .eoi_vec  (eoi_vector),
      .grant    (slot_grant[g]),
      .req      (slot_req[g]),
      .lo_word  (lo_words[g]),
      .hi_word  (hi_words[g]),
      .msg      (slot_msgs[g]),
      .level    (slot_level[g]),
      .rirr     (slot_rirr[g])
    );
  end

  always_comb begin
    data_rdata = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (in_range && offset[7:1] == 7'(i))
        data_rdata = index_q[0] ? hi_words[i] : lo_words[i];
    end
  end

  irq_route_arb #(.NPINS(NPINS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (slot_req),
    .msgs     (slot_msgs),
    .out_ready(msg_ready),
    .grant    (slot_grant),
    .out_valid(msg_valid),
    .out_msg  (out_msg)
  );

  assign msg_vector = out_msg.vec;
  assign msg_dest   = out_msg.dest;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_vector,
  input logic [7:0]       msg_dest,
  input logic [NPINS-1:0] grant,
  input logic [NPINS-1:0] req,
  input logic [NPINS-1:0] level,
  input logic [NPINS-1:0] rirr
);
  localparam logic [NPINS-1:0] ONE = NPINS'(1);

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)); // R11

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R10

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((req & (grant - ONE)) == '0)); // R10

  AST_GRANT_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> msg_valid); // R12

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    AST_LEVEL_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] && level[g] |=> rirr[g]); // R7
  end
endmodule

bind irq_route_ctrl irq_route_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_vector(msg_vector),
  .msg_dest  (msg_dest),
  .grant     (slot_grant),
  .req       (slot_req),
  .level     (slot_level),
  .rirr      (slot_rirr)
);

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
  localparam int NP = 4;
  // rows: {pin, vector, destination}
  localparam logic [23:0] EDGE_TAB [4] = '{
    {8'd2, 8'h22, 8'd3},
    {8'd0, 8'h20, 8'd1},
    {8'd3, 8'h23, 8'd4},
    {8'd1, 8'h21, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] irq_pin = '0;
  logic idx_we = 0, data_we = 0, eoi_valid = 0, msg_ready = 0;
  logic [7:0] idx_wdata = '0, eoi_vector = '0;
  logic [31:0] data_wdata = '0, data_rdata;
  logic msg_valid;
  logic [7:0] msg_vector, msg_dest;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_route_ctrl #(.NPINS(NP)) u_irq_route_ctrl (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] idx, logic [31:0] d);
    idx_we = 1; idx_wdata = idx; cyc(1); idx_we = 0;
    data_we = 1; data_wdata = d; cyc(1); data_we = 0;
  endtask

  task automatic rd(logic [7:0] idx, output logic [31:0] d);
    idx_we = 1; idx_wdata = idx; cyc(1); idx_we = 0;
    d = data_rdata;
  endtask

  task automatic accept();
    msg_ready = 1; cyc(1); msg_ready = 0;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1; eoi_vector = v; cyc(1); eoi_valid = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    cyc(2); rst_n = 1; cyc(1);
    check("R1 valid after reset", 32'(msg_valid), 0);
    rd(8'h10, d); check("R1 pin0 low", d, 32'h0001_0000);
    rd(8'h17, d); check("R1 pin3 high", d, 0);
    rd(8'h16, d); check("R1 pin3 low", d, 32'h0001_0000);

    for (int p = 0; p < NP; p++) begin
      wr(8'(16 + 2 * p), 32'h20 + p);
      wr(8'(17 + 2 * p), 32'(p + 1) << 24);
    end
    rd(8'h12, d); check("R2 pin1 low", d, 32'h21);
    rd(8'h15, d); check("R2 pin2 high", d, 32'h0300_0000);
    wr(8'h05, 32'hdead_beef);
    rd(8'h05, d); check("R2 out of range", d, 0);
    rd(8'h18, d); check("R2 past last", d, 0);
    wr(8'h10, 32'h4020);
    rd(8'h10, d); check("R3 rirr not writable", d, 32'h20);

    for (int r = 0; r < 4; r++) begin
      logic [7:0] p, v, ds;
      {p, v, ds} = EDGE_TAB[r];
      irq_pin[p] = 1; cyc(1); irq_pin[p] = 0;
      check("R12 valid before 2nd edge", 32'(msg_valid), 0);
      cyc(1);
      check("R5 edge message", 32'(msg_valid), 1);
      check("R4 vector", 32'(msg_vector), 32'(v));
      check("R4 dest", 32'(msg_dest), 32'(ds));
      accept(); cyc(3);
      check("R5 single message", 32'(msg_valid), 0);
    end
    rd(8'h12, d); check("R5 edge leaves rirr clear", d, 32'h21);

    wr(8'h10, 32'h0001_0020);
    irq_pin[0] = 1; cyc(1); irq_pin[0] = 0; cyc(3);
    check("R6 masked edge", 32'(msg_valid), 0);
    wr(8'h10, 32'h20); cyc(3);
    check("R6 dropped after unmask", 32'(msg_valid), 0);

    irq_pin[1] = 1; irq_pin[3] = 1; cyc(1); irq_pin[1] = 0; irq_pin[3] = 0; cyc(1);
    check("R10 lowest first", 32'(msg_vector), 32'h21);
    cyc(3);
    check("R11 held valid", 32'(msg_valid), 1);
    check("R11 held vector", 32'(msg_vector), 32'h21);
    msg_ready = 1; cyc(1);
    check("R12 handover valid", 32'(msg_valid), 1);
    check("R10 second pin", 32'(msg_vector), 32'h23);
    cyc(1); msg_ready = 0;
    check("R10 drained", 32'(msg_valid), 0);

    wr(8'h14, 32'h0000_8042);
    irq_pin[2] = 1; cyc(2);
    check("R7 level message", 32'(msg_vector), 32'h42);
    accept();
    rd(8'h14, d); check("R7 rirr set", d, 32'h0000_C042);
    cyc(3);
    check("R7 blocked", 32'(msg_valid), 0);
    eoi(8'h43); cyc(2);
    check("R8 unmatched eoi", 32'(msg_valid), 0);
    rd(8'h14, d); check("R8 rirr kept", d, 32'h0000_C042);
    eoi(8'h42); cyc(1);
    check("R8 matched eoi resend", 32'(msg_valid), 1);
    check("R8 vector", 32'(msg_vector), 32'h42);
    accept();

    wr(8'h14, 32'h0001_8042);
    wr(8'h14, 32'h0001_8055);
    wr(8'h14, 32'h0000_8055);
    eoi(8'h42); cyc(3);
    check("R9 stale eoi no message", 32'(msg_valid), 0);
    rd(8'h14, d); check("R9 rirr stuck", d, 32'h0000_C055);
    irq_pin[2] = 0; cyc(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule